// File: doc/BRIEF.md
# Interrupt Aggregation Unit

This block gathers the interrupt request lines of several slave ports onto one interrupt bus for a bus master, 32 positions wide by default. Each position of the bus is set at build time: the flat source line that drives it, and one of four trigger modes. The modes are level active-high, level active-low, rising edge and falling edge. Level active-high is the default. Every request leaves the block as an active-high bit. A flat source line is numbered port × lines-per-port + line.

Every source line and every spare input first passes through a two-flop synchronizer. A level line follows its synchronized, polarity-corrected input without latching. An edge line holds a sticky pending flag that stays set until software writes a 1 to that bit position through the clear strobe. Positions that no source claims follow a build-time policy: they read as zero, they pass the same-numbered bit of a spare input bus, or the whole output is switched off.

Top module: `irq_gather`

## Requirements
- R1: A line in mode 0 (level active-high) drives its bit to the value of its source line, two clock edges after the input changes, and drops again without latching.
- R2: A line in mode 1 (level active-low) drives its bit to the inverse of its source line, with the same two-edge latency.
- R3: A line in mode 2 (rising edge) sets its bit three edges after a 0-to-1 change of its source, and the bit stays set after the source returns to 0.
- R4: A line in mode 3 (falling edge) sets its bit three edges after a 1-to-0 change of its source, and the bit stays set after the source returns to 1.
- R5: With clr_we_i high at a clock edge, every edge-line bit whose clr_mask_i bit is 1 reads 0 after that edge, and edge-line bits whose mask bit is 0 keep their value.
- R6: When a selected edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R7: Under policy 0 (tie low), bits that no source claims always read 0.
- R8: Under policy 1 (spare), each unclaimed bit follows the same-numbered bit of spare_irq_i two edges later, and claimed bits ignore spare_irq_i.
- R9: Under policy 2 (no output), irq_o reads all zeros whatever the source, spare and clear inputs do.
- R10: After reset, with all sources at their inactive levels, irq_o is all zeros and no pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | N_PORTS*LINES_PER_PORT | Flat slave interrupt lines, asynchronous |
| spare_irq_i | input | IRQ_W | Spare interrupt lines for unclaimed positions, asynchronous |
| clr_we_i | input | 1 | Write strobe of the write-1-to-clear register |
| clr_mask_i | input | IRQ_W | Bits to clear in the pending flags |
| irq_o | output | IRQ_W | Active-high interrupt bus toward the master |

## Verification
The bench feeds the same inputs to three instances, one for each unused-line policy. It drives sources to their active and inactive levels for both level polarities, which tells a plain pass-through apart from an inverted one. It also shows that a level bit falls back without latching. It produces single edges in both directions and returns each source to idle afterwards, to tell a sticky flag from a level follower. It issues partial and full clear masks, and a clear that lands in the same cycle as a new edge, to show that set wins over clear. Changing spare patterns while all sources are active separates the routing of unclaimed bits from the routing of claimed bits under each policy.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    // Per-line trigger mode; encoding is visible in the LINE_MODE parameter.
    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    // Treatment of bus positions that no source claims.
    typedef enum logic [1:0] {
        UNUSED_TIE_LOW   = 2'd0,
        UNUSED_SPARE     = 2'd1,
        UNUSED_NO_OUTPUT = 2'd2
    } unused_e;

    localparam int SEL_W = 8;

    // State of one line cell.
    typedef struct packed {
        logic prev_act;
        logic pend;
    } line_st_t;

    function automatic logic trig_inverted(trig_e m);
        return (m == TRIG_LVL_LO) || (m == TRIG_FALL);
    endfunction

    function automatic logic trig_is_edge(trig_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{stage1: RST_VAL, stage2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage2;

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_gather_pkg::*;
#(
    parameter trig_e MODE = TRIG_LVL_HI
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic clr_i,
    output logic irq_o
);

    localparam logic INV     = trig_inverted(MODE);
    localparam logic IS_EDGE = trig_is_edge(MODE);

    line_st_t st_d, st_q;
    logic     act;
    logic     fire;

    always_comb begin
        act           = lvl_i ^ INV;
        fire          = act & ~st_q.prev_act;
        st_d          = st_q;
        st_d.prev_act = act;
        // a fresh edge wins over a clear in the same cycle
        st_d.pend     = (st_q.pend & ~clr_i) | fire;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    if (IS_EDGE) begin : g_edge
        assign irq_o = st_q.pend;
    end else begin : g_level
        assign irq_o = act;
    end

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int      N_PORTS        = 4,
    parameter int      LINES_PER_PORT = 2,
    parameter int      IRQ_W          = 32,
    parameter logic [IRQ_W*SEL_W-1:0] LINE_SRC = {
        {24{8'hFF}},
        8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01, 8'h00},
    parameter logic [IRQ_W*2-1:0] LINE_MODE = {
        {28{2'd0}}, 2'd3, 2'd2, 2'd1, 2'd0},
    parameter unused_e UNUSED_POLICY = UNUSED_TIE_LOW
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [N_PORTS*LINES_PER_PORT-1:0] src_irq_i,
    input  logic [IRQ_W-1:0]                  spare_irq_i,
    input  logic                              clr_we_i,
    input  logic [IRQ_W-1:0]                  clr_mask_i,
    output logic [IRQ_W-1:0]                  irq_o
);

    localparam int NSRC = N_PORTS * LINES_PER_PORT;

    // Sources feeding inverted lines idle high, so they reset high.
    function automatic logic [NSRC-1:0] calc_idle();
        logic [NSRC-1:0] v;
        v = '0;
        for (int i = 0; i < IRQ_W; i++) begin
            int    s;
            trig_e m;
            s = int'(LINE_SRC[i*SEL_W +: SEL_W]);
            m = trig_e'(LINE_MODE[i*2 +: 2]);
            if (s < NSRC && trig_inverted(m)) v[s] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [NSRC-1:0] SRC_IDLE = calc_idle();

    logic [NSRC-1:0]  src_sync;
    logic [IRQ_W-1:0] spare_sync;
    logic [IRQ_W-1:0] line_irq;
    logic             unused_bits;

    irq_sync #(.W(NSRC), .RST_VAL(SRC_IDLE)) u_src_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_irq_i),
        .sync_o  (src_sync)
    );

    irq_sync #(.W(IRQ_W), .RST_VAL('0)) u_spare_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (spare_irq_i),
        .sync_o  (spare_sync)
    );

    for (genvar i = 0; i < IRQ_W; i++) begin : g_line
        localparam int    SEL  = int'(LINE_SRC[i*SEL_W +: SEL_W]);
        localparam trig_e MODE = trig_e'(LINE_MODE[i*2 +: 2]);
        if (SEL < NSRC) begin : g_claimed
            irq_line_cell #(.MODE(MODE)) u_cell (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .lvl_i  (src_sync[SEL]),
                .clr_i  (clr_we_i & clr_mask_i[i]),
                .irq_o  (line_irq[i])
            );
        end else if (UNUSED_POLICY == UNUSED_SPARE) begin : g_spare
            assign line_irq[i] = spare_sync[i];
        end else begin : g_tie
            assign line_irq[i] = 1'b0;
        end
    end

    if (UNUSED_POLICY == UNUSED_NO_OUTPUT) begin : g_off
        assign irq_o = '0;
    end else begin : g_on
        assign irq_o = line_irq;
    end

    // sinks for bits a given mapping leaves unread
    assign unused_bits = ^{src_sync, spare_sync, clr_mask_i, line_irq};

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_gather_pkg::*;
#(
    parameter int      N_PORTS        = 4,
    parameter int      LINES_PER_PORT = 2,
    parameter int      IRQ_W          = 32,
    parameter logic [IRQ_W*SEL_W-1:0] LINE_SRC  = '1,
    parameter logic [IRQ_W*2-1:0]     LINE_MODE = '0,
    parameter unused_e UNUSED_POLICY  = UNUSED_TIE_LOW
) (
    input logic                              clk_i,
    input logic                              rst_ni,
    input logic [N_PORTS*LINES_PER_PORT-1:0] src_irq_i,
    input logic [IRQ_W-1:0]                  spare_irq_i,
    input logic                              clr_we_i,
    input logic [IRQ_W-1:0]                  clr_mask_i,
    input logic [IRQ_W-1:0]                  irq_o
);

    localparam int NSRC = N_PORTS * LINES_PER_PORT;

    // cycles since reset release, saturating
    logic [2:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) warm_q <= '0;
        else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end

    if (UNUSED_POLICY == UNUSED_NO_OUTPUT) begin : g_off
        p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o == '0);
    end else begin : g_on
        for (genvar i = 0; i < IRQ_W; i++) begin : g_line
            localparam int    SEL  = int'(LINE_SRC[i*SEL_W +: SEL_W]);
            localparam trig_e MODE = trig_e'(LINE_MODE[i*2 +: 2]);
            localparam logic  INV  = trig_inverted(MODE);
            if (SEL >= NSRC) begin : g_free
                if (UNUSED_POLICY == UNUSED_SPARE) begin : g_spare
                    p_spare_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                        (warm_q >= 3'd3) |-> (irq_o[i] == $past(spare_irq_i[i], 2)));
                end else begin : g_tie
                    p_unclaimed_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                        irq_o[i] == 1'b0);
                end
            end else if (trig_is_edge(MODE)) begin : g_edge
                p_edge_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    ((warm_q >= 3'd5) && ($past(src_irq_i[SEL], 3) ^ INV)
                     && !($past(src_irq_i[SEL], 4) ^ INV)) |-> irq_o[i]);
                p_pend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    ((warm_q >= 3'd1) && $past(irq_o[i])
                     && !$past(clr_we_i && clr_mask_i[i])) |-> irq_o[i]);
            end else begin : g_level
                p_level_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (warm_q >= 3'd3) |-> (irq_o[i] == ($past(src_irq_i[SEL], 2) ^ INV)));
            end
        end
    end

endmodule

bind irq_gather irq_gather_chk #(
    .N_PORTS        (N_PORTS),
    .LINES_PER_PORT (LINES_PER_PORT),
    .IRQ_W          (IRQ_W),
    .LINE_SRC       (LINE_SRC),
    .LINE_MODE      (LINE_MODE),
    .UNUSED_POLICY  (UNUSED_POLICY)
) chk_i (.*);

// File: tb/irq_gather_tb_top.sv
module irq_gather_tb_top;
    import irq_gather_pkg::*;

    // Mapping under test (defaults): bit i <- source i for i < 8;
    // bit0 mode 0, bit1 mode 1, bit2 mode 2, bit3 mode 3, bits 4..7 mode 0.
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = 8'h0A;   // idle: inverted sources 1 and 3 high
    logic [31:0] spare = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_mask = '0;
    logic [31:0] irq_tie, irq_spr, irq_off;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          which;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    irq_gather dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src), .spare_irq_i(spare),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .irq_o(irq_tie));

    irq_gather #(.UNUSED_POLICY(UNUSED_SPARE)) dut_spare (
        .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src), .spare_irq_i(spare),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .irq_o(irq_spr));

    irq_gather #(.UNUSED_POLICY(UNUSED_NO_OUTPUT)) dut_off (
        .clk_i(clk), .rst_ni(rst_n), .src_irq_i(src), .spare_irq_i(spare),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask), .irq_o(irq_off));

    task automatic push(int which, logic [31:0] exp, string req);
        item_t it;
        it.which = which;
        it.exp   = exp;
        it.req   = req;
        sb_q.push_back(it);
    endtask

    // expected values for all three instances; off instance always zero (R9)
    task automatic expect3(logic [31:0] e_tie, logic [31:0] e_spr, string req);
        push(0, e_tie, req);
        push(1, e_spr, req);
        push(2, 32'h0, {req, "/R9"});
    endtask

    task automatic settle_and_expect(logic [31:0] e_tie, logic [31:0] e_spr, string req);
        repeat (3) @(posedge clk);
        expect3(e_tie, e_spr, req);
        @(negedge clk);
    endtask

    task automatic clear(logic [31:0] mask, logic [31:0] e_tie, logic [31:0] e_spr, string req);
        clr_we   = 1'b1;
        clr_mask = mask;
        @(posedge clk);
        expect3(e_tie, e_spr, req);
        @(negedge clk);
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    // monitor: compares at negedge, away from the edge that updates outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.which == 0) ? irq_tie : (it.which == 1) ? irq_spr : irq_off;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s inst%0d: got %08h expected %08h",
                             it.req, it.which, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state with idle inputs
        settle_and_expect(32'h0, 32'h0, "R10");

        // R1: level active-high lines 0 and 5
        src[0] = 1'b1; src[5] = 1'b1;
        settle_and_expect(32'h21, 32'h21, "R1");
        // R2: level active-low line 1 asserted by driving low
        src[1] = 1'b0;
        settle_and_expect(32'h23, 32'h23, "R2");
        // R1/R2: release, no latching
        src[0] = 1'b0; src[5] = 1'b0; src[1] = 1'b1;
        settle_and_expect(32'h0, 32'h0, "R1");

        // R3: rising edge on line 2, then source drops, flag sticks
        src[2] = 1'b1;
        settle_and_expect(32'h04, 32'h04, "R3");
        src[2] = 1'b0;
        settle_and_expect(32'h04, 32'h04, "R3");
        // R4: falling edge on line 3, then source returns high
        src[3] = 1'b0;
        settle_and_expect(32'h0C, 32'h0C, "R4");
        src[3] = 1'b1;
        settle_and_expect(32'h0C, 32'h0C, "R4");

        // R5: partial clear leaves bit 2, full clear empties
        clear(32'h08, 32'h04, 32'h04, "R5");
        clear(32'hFFFF_FFFF, 32'h0, 32'h0, "R5");

        // R6: clear lands in the cycle the new edge is detected
        src[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        clear(32'h04, 32'h04, 32'h04, "R6");
        src[2] = 1'b0;

        // R7/R8: spare pattern, claimed bits unaffected by spare
        spare = 32'hA5A5_A5FF;
        settle_and_expect(32'h04, 32'hA5A5_A504, "R8");
        // R7: all sources active, unclaimed stay low in tie instance
        src = 8'hFF;
        settle_and_expect(32'hF5, 32'hA5A5_A5F5, "R7");
        spare = 32'h5A5A_5A00;
        settle_and_expect(32'hF5, 32'h5A5A_5AF5, "R8");
        // R9: clear strobe with everything active, off instance still quiet
        clear(32'hFFFF_FFFF, 32'hF1, 32'h5A5A_5AF1, "R5");

        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule